// File: doc/BRIEF.md
# Bitwise Logic Unit with Flags

This block is the bitwise-logic execution stage of a 64-bit processor datapath. It takes a first operand, a second operand and an operation request, and returns the logic result together with a register write-enable, a flag-update strobe and the four condition flags (negative, zero, carry, overflow). The second operand is either a register value passed through a barrel shifter (shift left, logical shift right, arithmetic shift right or rotate right by 0 to 63) or an already decoded 64-bit immediate, which is used unshifted.

Three base functions (AND, OR, XOR) can each take the second operand complemented, giving six operations: AND, bit clear, OR, OR-NOT, XOR and XOR-NOT. Only the AND-type operations may update flags; when they do, negative and zero come from the result and carry and overflow are forced to zero. A destination of the zero register turns any operation into a test: flags are still updated but nothing is written. Forcing the first operand to zero gives the move (OR) and move-inverted (OR-NOT) aliases. Combinations that have no valid encoding (complement with an immediate, flag update on a non-AND function, reserved function code) are reported as illegal and neither write nor update flags.

Requests enter on a valid/ready handshake and results leave on another, through a single register stage. A request is taken on a clock edge where `in_valid` and `in_ready` are both high; `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so the stage sustains one request per cycle with no bubbles. While `out_valid` is high and `out_ready` is low, the result and its side-band outputs are held unchanged.

Top module: `bitlogic_unit`

## Requirements
- R1: With `op_fn` 00 = AND, 01 = OR, 10 = XOR and `op_inv` complementing the second operand, the result is a&b, a&~b, a|b, a|~b, a^b or a^~b.
- R2: In register form (`use_imm` = 0) the second operand is `op_b` shifted by `sh_amt` with `sh_type` 00 = shift left, 01 = logical shift right, 10 = arithmetic shift right, 11 = rotate right; an amount of 0 passes `op_b` unchanged.
- R3: With `use_imm` = 1 the second operand is `imm`, unshifted; an immediate together with `op_inv` = 1, or `op_fn` = 11, sets `illegal`.
- R4: `set_flags` = 1 is legal only with `op_fn` = 00 (AND or bit clear); with any other function it sets `illegal` and `flag_we` stays low.
- R5: When `flag_we` is high, `flags` = {N, Z, C, V} with N = result bit 63, Z = 1 exactly when the result is all zero, and C = V = 0.
- R6: With `dst_zero` = 1 a legal request gives `wr_en` = 0 while `flag_we` still follows `set_flags` (test operation); otherwise a legal request gives `wr_en` = 1.
- R7: With `a_zero` = 1 the first operand is taken as zero, so OR gives the second operand (move) and OR-NOT gives its complement (move inverted).
- R8: For a non-flag-setting or illegal request `flag_we` is 0 and `flags` reads 0000; an illegal request also gives `wr_en` = 0.
- R9: A result appears with `out_valid` on the clock edge after acceptance; `in_ready` = !out_valid | out_ready; a result not taken is held stable.
- R10: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Stage can accept a request |
| op_fn | input | 2 | Base function: 00 AND, 01 OR, 10 XOR, 11 reserved |
| op_inv | input | 1 | Complement the second operand |
| use_imm | input | 1 | Second operand is the immediate |
| set_flags | input | 1 | Request a flag update |
| dst_zero | input | 1 | Destination is the zero register |
| a_zero | input | 1 | Take the first operand as zero |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Register second operand |
| imm | input | 64 | Decoded immediate |
| sh_type | input | 2 | Shift kind for the register operand |
| sh_amt | input | 6 | Shift amount |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| result | output | 64 | Logic result |
| wr_en | output | 1 | Destination write enable |
| flag_we | output | 1 | Flag update strobe |
| flags | output | 4 | {N, Z, C, V} |
| illegal | output | 1 | Request has no valid encoding |

## Verification
Every result is due exactly one clock edge after the edge that accepted its request, and stays due until the edge where `out_ready` is high. The bench drives inputs just after the falling edge, samples `in_ready` and all outputs one time unit later, and keeps a one-entry model of the output register that it loads on acceptance and clears on drain; whenever the model holds an entry, every output is compared against it, so held results are rechecked on each stalled cycle. `out_valid` is compared against the model's occupancy every cycle.

// File: rtl/bitlogic_pkg.sv
package bitlogic_pkg;
  localparam int DW = 64;
  localparam int SW = $clog2(DW);

  typedef enum logic [1:0] {
    FN_AND = 2'b00,
    FN_OR  = 2'b01,
    FN_XOR = 2'b10,
    FN_RSV = 2'b11
  } fn_e;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_e;

  // Flag vector positions
  localparam int FLG_N = 3;
  localparam int FLG_Z = 2;
  localparam int FLG_C = 1;
  localparam int FLG_V = 0;
endpackage

// File: rtl/bitlogic_shifter.sv
module bitlogic_shifter #(
  parameter int W  = 64,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [1:0]    kind,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  dout
);
  import bitlogic_pkg::*;

  logic [2*W-1:0] rot_wide;

  always_comb begin
    rot_wide = {din, din} >> amt;
    unique case (shift_e'(kind))
      SH_LSL:  dout = din << amt;
      SH_LSR:  dout = din >> amt;
      SH_ASR:  dout = W'($signed(din) >>> amt);
      default: dout = rot_wide[W-1:0];
    endcase
  end
endmodule

// File: rtl/bitlogic_core.sv
module bitlogic_core #(
  parameter int W  = 64,
  localparam int AW = $clog2(W)
) (
  input  logic [1:0]    op_fn,
  input  logic          op_inv,
  input  logic          use_imm,
  input  logic          set_flags,
  input  logic          dst_zero,
  input  logic          a_zero,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic [W-1:0]  imm,
  input  logic [1:0]    sh_type,
  input  logic [AW-1:0] sh_amt,
  output logic [W-1:0]  res,
  output logic          wr_en,
  output logic          flag_we,
  output logic [3:0]    flags,
  output logic          illegal
);
  import bitlogic_pkg::*;

  logic [W-1:0] b_shifted;
  logic [W-1:0] b_sel;
  logic [W-1:0] b_eff;
  logic [W-1:0] a_eff;
  logic         legal;

  bitlogic_shifter #(.W(W)) u_shift (
    .din  (op_b),
    .kind (sh_type),
    .amt  (sh_amt),
    .dout (b_shifted)
  );

  // Per-bit operand conditioning: immediate bypasses the shifter
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign b_sel[i] = use_imm ? imm[i] : b_shifted[i];
    assign b_eff[i] = b_sel[i] ^ op_inv;
    assign a_eff[i] = op_a[i] & ~a_zero;
  end

  always_comb begin
    unique case (fn_e'(op_fn))
      FN_AND:  res = a_eff & b_eff;
      FN_OR:   res = a_eff | b_eff;
      FN_XOR:  res = a_eff ^ b_eff;
      default: res = '0;
    endcase
  end

  always_comb begin
    legal = 1'b1;
    if (fn_e'(op_fn) == FN_RSV)                 legal = 1'b0;
    if (use_imm && op_inv)                       legal = 1'b0;
    if (set_flags && (fn_e'(op_fn) != FN_AND))   legal = 1'b0;
  end

  always_comb begin
    illegal = ~legal;
    wr_en   = legal & ~dst_zero;
    flag_we = legal & set_flags;
    flags   = '0;
    if (flag_we) begin
      flags[FLG_N] = res[W-1];
      flags[FLG_Z] = ~|res;
      flags[FLG_C] = 1'b0;
      flags[FLG_V] = 1'b0;
    end
  end
endmodule

// File: rtl/bitlogic_unit.sv
module bitlogic_unit #(
  parameter int W  = 64,
  localparam int AW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    op_fn,
  input  logic          op_inv,
  input  logic          use_imm,
  input  logic          set_flags,
  input  logic          dst_zero,
  input  logic          a_zero,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic [W-1:0]  imm,
  input  logic [1:0]    sh_type,
  input  logic [AW-1:0] sh_amt,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  result,
  output logic          wr_en,
  output logic          flag_we,
  output logic [3:0]    flags,
  output logic          illegal
);
  logic [W-1:0] c_res;
  logic         c_wr;
  logic         c_fwe;
  logic [3:0]   c_flags;
  logic         c_ill;
  logic         take;

  bitlogic_core #(.W(W)) u_core (
    .op_fn     (op_fn),
    .op_inv    (op_inv),
    .use_imm   (use_imm),
    .set_flags (set_flags),
    .dst_zero  (dst_zero),
    .a_zero    (a_zero),
    .op_a      (op_a),
    .op_b      (op_b),
    .imm       (imm),
    .sh_type   (sh_type),
    .sh_amt    (sh_amt),
    .res       (c_res),
    .wr_en     (c_wr),
    .flag_we   (c_fwe),
    .flags     (c_flags),
    .illegal   (c_ill)
  );

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      wr_en     <= 1'b0;
      flag_we   <= 1'b0;
      flags     <= '0;
      illegal   <= 1'b0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        result    <= c_res;
        wr_en     <= c_wr;
        flag_we   <= c_fwe;
        flags     <= c_flags;
        illegal   <= c_ill;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R5: carry and overflow cleared on any flag update
  p_cv_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flag_we |-> flags[1:0] == 2'b00);

  // R5: zero flag agrees with the registered result
  p_zflag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flag_we |-> flags[2] == (result == '0));

  // R4: flag update on a non-AND function is rejected
  p_flag_only_and_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take && set_flags && op_fn != 2'b00 |=> illegal && !flag_we);

  // R3: immediate with complement is rejected
  p_imm_inv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take && use_imm && op_inv |=> illegal && !wr_en);

  // R6: zero destination never writes
  p_zero_dst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take && dst_zero |=> !wr_en);

  // R8: no strobe, no flags
  p_flags_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !flag_we |-> flags == 4'b0000);

  // R9: stalled result is held
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(result) && $stable(flags));
endmodule

// File: tb/bitlogic_unit_test.sv
module bitlogic_unit_test;
  localparam int  W   = 64;
  localparam time TCK = 10;

  typedef struct packed {
    logic [W-1:0] res;
    logic         wr;
    logic         fwe;
    logic [3:0]   flg;
    logic         ill;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
  logic [1:0] op_fn = '0, sh_type = '0;
  logic op_inv = 0, use_imm = 0, set_flags = 0, dst_zero = 0, a_zero = 0;
  logic [W-1:0] op_a = '0, op_b = '0, imm = '0, result;
  logic [5:0] sh_amt = '0;
  logic wr_en, flag_we, illegal;
  logic [3:0] flags;

  int n_chk = 0, n_bad = 0;
  bit   pend = 0;
  exp_t exp_q;
  string cur_tag = "R1";

  always #(TCK/2) clk = ~clk;

  bitlogic_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_fn(op_fn), .op_inv(op_inv), .use_imm(use_imm), .set_flags(set_flags),
    .dst_zero(dst_zero), .a_zero(a_zero), .op_a(op_a), .op_b(op_b), .imm(imm),
    .sh_type(sh_type), .sh_amt(sh_amt), .out_valid(out_valid),
    .out_ready(out_ready), .result(result), .wr_en(wr_en), .flag_we(flag_we),
    .flags(flags), .illegal(illegal)
  );

  function automatic logic [W-1:0] ref_shift(logic [W-1:0] v, logic [1:0] k, int n);
    logic [W-1:0] o;
    for (int i = 0; i < W; i++) begin
      case (k)
        2'd0: o[i] = (i - n >= 0) ? v[i-n] : 1'b0;
        2'd1: o[i] = (i + n < W) ? v[i+n] : 1'b0;
        2'd2: o[i] = (i + n < W) ? v[i+n] : v[W-1];
        default: o[i] = v[(i+n) % W];
      endcase
    end
    return o;
  endfunction

  function automatic exp_t ref_model();
    exp_t e;
    logic [W-1:0] a, b;
    logic ok;
    a = a_zero ? '0 : op_a;
    b = use_imm ? imm : ref_shift(op_b, sh_type, int'(sh_amt));
    if (op_inv) b = ~b;
    case (op_fn)
      2'd0: e.res = a & b;
      2'd1: e.res = a | b;
      2'd2: e.res = a ^ b;
      default: e.res = '0;
    endcase
    ok = (op_fn != 2'd3) && !(use_imm && op_inv) && !(set_flags && op_fn != 2'd0);
    e.ill = !ok;
    e.wr  = ok && !dst_zero;
    e.fwe = ok && set_flags;
    e.flg = e.fwe ? {e.res[W-1], (e.res == '0), 2'b00} : 4'b0000;
    return e;
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] ex);
    n_chk++;
    if (act !== ex) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (test %s)", tag, act, ex, cur_tag);
    end
  endtask

  // One clock: inputs already driven after the falling edge
  task automatic step();
    bit acc;
    exp_t nx;
    #1;
    chk("R9 out_valid", W'(out_valid), W'(pend));
    chk("R9 in_ready", W'(in_ready), W'(!pend || out_ready));
    if (pend) begin
      chk("R1 result", result, exp_q.res);
      chk("R6 wr_en", W'(wr_en), W'(exp_q.wr));
      chk("R4 flag_we", W'(flag_we), W'(exp_q.fwe));
      chk("R5 flags", W'(flags), W'(exp_q.flg));
      chk("R3 illegal", W'(illegal), W'(exp_q.ill));
    end
    acc = in_valid && (!pend || out_ready);
    nx  = ref_model();
    @(posedge clk);
    if (acc) begin pend = 1; exp_q = nx; end
    else if (out_ready) pend = 0;
    @(negedge clk);
  endtask

  task automatic issue(string tag, logic [1:0] fn, logic inv, logic im, logic sf,
                       logic dz, logic az, logic [W-1:0] a, logic [W-1:0] b,
                       logic [W-1:0] iv, logic [1:0] st, logic [5:0] sa);
    cur_tag = tag;
    op_fn = fn; op_inv = inv; use_imm = im; set_flags = sf; dst_zero = dz;
    a_zero = az; op_a = a; op_b = b; imm = iv; sh_type = st; sh_amt = sa;
    in_valid = 1; out_ready = 1;
    step();
    in_valid = 0;
    step();
  endtask

  initial begin : watchdog
    #(TCK * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    cur_tag = "R10";
    chk("R10 out_valid after reset", W'(out_valid), '0);
    chk("R10 in_ready after reset", W'(in_ready), 64'd1);
    @(negedge clk);

    // Directed corner cases
    issue("R1 and",  2'd0, 0, 0, 0, 0, 0, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_00FF_00FF, 0, 2'd0, 6'd0);
    issue("R1 bic",  2'd0, 1, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h00FF_0000_1111_0000, 0, 2'd0, 6'd0);
    issue("R1 orn",  2'd1, 1, 0, 0, 0, 0, 64'h1, 64'hFFFF_FFFF_FFFF_FFF0, 0, 2'd0, 6'd0);
    issue("R1 eon",  2'd2, 1, 0, 0, 0, 0, 64'hAAAA_5555_AAAA_5555, 64'hAAAA_5555_0000_FFFF, 0, 2'd0, 6'd0);
    issue("R2 lsl0", 2'd1, 0, 0, 0, 0, 1, 0, 64'h8123_4567_89AB_CDEF, 0, 2'd0, 6'd0);
    issue("R2 ror1", 2'd1, 0, 0, 0, 0, 1, 0, 64'h1, 0, 2'd3, 6'd1);
    issue("R2 asr63",2'd1, 0, 0, 0, 0, 1, 0, 64'h8000_0000_0000_0000, 0, 2'd2, 6'd63);
    issue("R2 lsr63",2'd1, 0, 0, 0, 0, 1, 0, 64'h8000_0000_0000_0000, 0, 2'd1, 6'd63);
    issue("R3 imm unshifted", 2'd2, 0, 1, 0, 0, 0, 64'hFF, 64'h1, 64'h5555_5555_5555_5555, 2'd0, 6'd9);
    issue("R3 imm+inv illegal", 2'd0, 1, 1, 0, 0, 0, 64'hFF, 0, 64'h0F, 2'd0, 6'd0);
    issue("R3 reserved fn", 2'd3, 0, 0, 0, 0, 0, 64'hFF, 64'hFF, 0, 2'd0, 6'd0);
    issue("R4 xor flags illegal", 2'd2, 0, 0, 1, 0, 0, 64'h1, 64'h2, 0, 2'd0, 6'd0);
    issue("R4 orr flags illegal", 2'd1, 1, 0, 1, 0, 0, 64'h1, 64'h2, 0, 2'd0, 6'd0);
    issue("R5 Z set", 2'd0, 0, 0, 1, 0, 0, 64'hF0, 64'h0F, 0, 2'd0, 6'd0);
    issue("R5 N set", 2'd0, 1, 0, 1, 0, 0, 64'h8000_0000_0000_0001, 64'h1, 0, 2'd0, 6'd0);
    issue("R6 test op", 2'd0, 0, 1, 1, 1, 0, 64'h0000_0000_0000_0010, 0, 64'h10, 2'd0, 6'd0);
    issue("R7 move", 2'd1, 0, 0, 0, 0, 1, 64'hDEAD_BEEF_DEAD_BEEF, 64'h0123_4567_89AB_CDEF, 0, 2'd0, 6'd4);
    issue("R7 move inverted", 2'd1, 1, 0, 0, 0, 1, 64'hDEAD_BEEF_DEAD_BEEF, 64'h0123_4567_89AB_CDEF, 0, 2'd0, 6'd0);
    issue("R8 no flag op", 2'd2, 0, 0, 0, 0, 0, 64'h0, 64'h0, 0, 2'd0, 6'd0);

    // Back-pressure: result stalled for several cycles (R9)
    cur_tag = "R9 stall";
    op_fn = 2'd0; op_inv = 0; use_imm = 0; set_flags = 1; dst_zero = 0; a_zero = 0;
    op_a = 64'h8000_0000_FFFF_0000; op_b = 64'hFFFF_FFFF_FFFF_FFFF; sh_type = 0; sh_amt = 0;
    in_valid = 1; out_ready = 0;
    repeat (4) step();
    out_ready = 1;
    step();
    in_valid = 0;
    step();

    // Constrained random, random back-pressure
    for (int n = 0; n < 3000; n++) begin
      cur_tag = "R1 random";
      in_valid  = ($urandom_range(0, 3) != 0);
      out_ready = ($urandom_range(0, 3) != 0);
      op_fn     = ($urandom_range(0, 9) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
      op_inv    = 1'($urandom);
      use_imm   = ($urandom_range(0, 3) == 0);
      set_flags = ($urandom_range(0, 2) == 0);
      dst_zero  = ($urandom_range(0, 4) == 0);
      a_zero    = ($urandom_range(0, 5) == 0);
      op_a      = {$urandom, $urandom};
      op_b      = ($urandom_range(0, 7) == 0) ? 64'h0 : {$urandom, $urandom};
      imm       = {$urandom, $urandom};
      sh_type   = 2'($urandom);
      sh_amt    = ($urandom_range(0, 5) == 0) ? 6'd0 : 6'($urandom);
      step();
    end
    in_valid = 0; out_ready = 1;
    step(); step();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule